// File: doc/BRIEF.md
# Stepped Counter with Periodic Tick

This block is an up counter whose increment on each enabled clock is taken from a run-time input instead of being fixed at one. The running value is held in a register and presented on `count`, so every change becomes visible one clock after the edge that caused it. A synchronous reset clears the counter, and a low `enable` freezes it.

The same counter also serves as a rate divider. An equality comparator watches the count against the terminal value `TERMINAL`. When an enabled edge finds the count at that value, the counter restarts at zero and the registered `tick` output is high for one clock. With `step` held at one, this gives one tick every `TERMINAL+1` enabled clocks. The tick is a synchronous one-clock pulse and is not meant to drive a clock net.

The block carries no data stream, so it has no valid/ready handshake. Every pin is a plain control or status signal that is sampled or updated on each rising edge of `clk`. There is no back-pressure: the block accepts `step` on every enabled edge.

Top module: `stepdiv_counter`

## Requirements
- R1: While `rst` is high at a rising edge, `count` becomes 0 and `tick` becomes 0 after that edge.
- R2: `rst` overrides `enable`. A high `enable` together with `rst` still clears the counter.
- R3: At an edge where `rst` is low and `enable` is low, `count` keeps its value and `tick` is 0 after the edge.
- R4: At an enabled edge where `count` differs from `TERMINAL`, the next `count` equals `count + step`, and it is visible after that edge.
- R5: The addition wraps modulo 2^WIDTH and never saturates. For example, with WIDTH=8, 200 + 200 gives 144.
- R6: At an enabled edge where `count` equals `TERMINAL`, the next `count` is 0 and `tick` is 1 for exactly the following clock.
- R7: With `step` = 1, consecutive `tick` pulses are separated by exactly `TERMINAL+1` enabled edges, whatever pattern of disabled cycles lies between them.
- R8: `tick` is 0 after every edge that is not an enabled edge at which `count` equals `TERMINAL`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Allows the counter to advance at this edge |
| step | input | WIDTH | Amount added at each enabled edge |
| count | output | WIDTH | Registered counter value |
| tick | output | 1 | One-clock pulse after a terminal-value restart |

## Verification
The bench targets several corner cases, each paired with the fault it would expose.

- Large steps that wrap past 2^WIDTH: a saturating or widened adder would drift away from the modular sequence.
- Reset asserted together with enable: a design that lets enable win would keep counting.
- Runs of disabled cycles in the middle of a divide period: a counter that advances or pulses while disabled would lengthen or shorten the measured tick period.
- Landing exactly on the terminal value through a non-unit step: a comparator placed after the adder, or a tick that is not registered, would misplace the restart or stretch the pulse.

// File: rtl/stepdiv_pkg.sv
package stepdiv_pkg;

  // Action applied to the counter register at the next edge.
  typedef enum logic [1:0] {
    ACT_CLEAR   = 2'd0,
    ACT_HOLD    = 2'd1,
    ACT_ADD     = 2'd2,
    ACT_RESTART = 2'd3
  } act_e;

endpackage

// File: rtl/stepdiv_match.sv
module stepdiv_match #(
  parameter int WIDTH    = 8,
  parameter int TERMINAL = 9,
  parameter bit DIV_EN   = 1'b1
) (
  input  logic [WIDTH-1:0] value,
  output logic             hit
);
  localparam logic [WIDTH-1:0] TERM_V = WIDTH'(TERMINAL);

  generate
    if (DIV_EN) begin : g_cmp
      assign hit = (value == TERM_V);
    end else begin : g_nocmp
      logic [WIDTH-1:0] unused_value;
      assign unused_value = value;
      assign hit = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/stepdiv_ctrl.sv
module stepdiv_ctrl
  import stepdiv_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic hit,
  output act_e act,
  output logic tick_q
);
  always_comb begin
    if (rst)         act = ACT_CLEAR;
    else if (!enable) act = ACT_HOLD;
    else if (hit)     act = ACT_RESTART;
    else              act = ACT_ADD;
  end

  always_ff @(posedge clk) begin
    if (rst) tick_q <= 1'b0;
    else     tick_q <= enable & hit;
  end

  // The pulse lasts one clock unless the terminal value is reached again at once.
  assert_tick_needs_hit_R8: assert property (@(posedge clk) disable iff (rst)
    tick_q |-> $past(enable) && $past(hit));
  assert_tick_low_when_idle_R3: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !tick_q);
endmodule

// File: rtl/stepdiv_accum.sv
module stepdiv_accum
  import stepdiv_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  act_e             act,
  input  logic [WIDTH-1:0] step,
  output logic [WIDTH-1:0] value
);
  logic [WIDTH-1:0] sum;
  assign sum = value + step;  // truncation gives modular wrap

  always_ff @(posedge clk) begin
    case (act)
      ACT_CLEAR, ACT_RESTART: value <= '0;
      ACT_ADD:                value <= sum;
      default:                value <= value;
    endcase
  end
endmodule

// File: rtl/stepdiv_counter.sv
module stepdiv_counter
  import stepdiv_pkg::*;
#(
  parameter int WIDTH    = 8,
  parameter int TERMINAL = 9,
  parameter bit DIV_EN   = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [WIDTH-1:0] step,
  output logic [WIDTH-1:0] count,
  output logic             tick
);
  localparam logic [WIDTH-1:0] TERM_V = WIDTH'(TERMINAL);

  logic hit;
  act_e act;

  stepdiv_match #(.WIDTH(WIDTH), .TERMINAL(TERMINAL), .DIV_EN(DIV_EN)) u_match (
    .value(count), .hit(hit)
  );

  stepdiv_ctrl u_ctrl (
    .clk(clk), .rst(rst), .enable(enable), .hit(hit), .act(act), .tick_q(tick)
  );

  stepdiv_accum #(.WIDTH(WIDTH)) u_accum (
    .clk(clk), .act(act), .step(step), .value(count)
  );

  // R2: reset clears even when enable is high at the same edge.
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (count == '0) && !tick);
  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !enable |=> $stable(count));
  assert_add_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    (enable && count != TERM_V) |=> count == WIDTH'($past(count) + $past(step)));
  assert_restart_R6: assert property (@(posedge clk) disable iff (rst)
    tick |-> count == '0);
endmodule

// File: tb/stepdiv_counter_bench.sv
module stepdiv_counter_bench;
  localparam int W = 8;
  localparam int TERM = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b0;
  logic [W-1:0] step = '0;
  logic [W-1:0] count;
  logic tick;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  string tag = "R1";
  bit started = 1'b0;
  bit period_arm = 1'b0;
  bit seen_tick = 1'b0;
  int ens = 0;
  int m_cnt = 0;
  bit m_tick = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  stepdiv_counter #(.WIDTH(W), .TERMINAL(TERM), .DIV_EN(1'b1)) u_stepdiv_counter (
    .clk(clk), .rst(rst), .enable(enable), .step(step), .count(count), .tick(tick)
  );

  // Behavioural reference, updated at each edge from the applied inputs.
  always @(posedge clk) begin
    cycles++;
    started = 1'b1;
    if (rst) begin
      m_cnt = 0; m_tick = 1'b0;
    end else if (enable) begin
      ens++;
      if (m_cnt == TERM) begin m_cnt = 0; m_tick = 1'b1; end
      else begin m_cnt = (m_cnt + int'(step)) % (1 << W); m_tick = 1'b0; end
    end else begin
      m_tick = 1'b0;
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      compared++;
      if (int'(count) != m_cnt || tick != m_tick) begin
        mismatched++;
        $display("FAIL %s: count=%0d tick=%0b expected count=%0d tick=%0b",
                 tag, count, tick, m_cnt, m_tick);
      end
      if (tick) begin
        if (period_arm && seen_tick) begin
          compared++;
          if (ens != TERM + 1) begin
            mismatched++;
            $display("FAIL R7: period=%0d expected=%0d", ens, TERM + 1);
          end
        end
        seen_tick = 1'b1;
        ens = 0;
      end
      if (cycles > 5000) begin
        mismatched++;
        $display("FAIL watchdog: cycles=%0d expected<=5000", cycles);
        done = 1'b1;
      end
    end
  end

  task automatic run(input int n, input bit en_v, input int st);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      enable = en_v; step = W'(st);
    end
  endtask

  initial begin
    tag = "R1"; rst = 1'b1;
    run(3, 1'b0, 0);
    @(negedge clk); rst = 1'b0;
    tag = "R3"; run(4, 1'b0, 5);
    tag = "R4"; run(3, 1'b1, 3); run(2, 1'b0, 3); run(6, 1'b1, 2);
    tag = "R2"; run(2, 1'b1, 7); rst = 1'b1; run(2, 1'b1, 7);
    rst = 1'b0;
    tag = "R5"; run(12, 1'b1, 200);
    rst = 1'b1; run(1, 1'b0, 0); rst = 1'b0;
    tag = "R6"; run(25, 1'b1, 1);
    tag = "R7"; seen_tick = 1'b0; period_arm = 1'b1;
    run(40, 1'b1, 1);
    for (int i = 0; i < 60; i++) run(1, (i % 3) != 0, 1);
    period_arm = 1'b0;
    tag = "R8"; run(10, 1'b1, 4); run(5, 1'b0, 4);
    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    wait (done);
    if (cycles > 5000) begin
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule